// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. It accepts one signed sample. It then walks the bits of the current sample and of every delayed sample, from the least significant bit upward. At each step it takes one bit from each tap and uses these bits as addresses into small precomputed tables. Each table covers two taps and holds every possible sum of their coefficients. The table results are added together. A shift-and-add accumulator then combines the per-bit sums into the full-precision output.

The parameter `BPC` sets how many bit positions are handled per clock. With `BPC = 1` the filter is purely bit-serial and takes `IN_W` cycles per sample. With `BPC = IN_W` it is fully parallel and produces one result per clock. Values in between trade table copies for cycles. The host drives a sample with a valid strobe whenever the ready output is high. The filter answers with a one-cycle output strobe.

Top module: `dafir_top`

## Requirements
- R1: Each result equals the exact sum over k of c[k]·x[n−k], where x[n] is the newest accepted sample and k runs over 0..TAPS−1. The result is a two's-complement value of IN_W+COEF_W+ceil(log2 TAPS) bits, so it never overflows.
- R2: Reset empties the sample history, so results that follow reset treat all earlier samples as zero.
- R3: A sample is taken at a rising edge where in_valid and in_ready are both 1. After that edge in_ready stays 0 for PHASES−1 cycles, where PHASES = IN_W/BPC. It is 1 again in the cycle in which the result is presented.
- R4: out_valid is 1 for exactly one cycle per accepted sample. It rises PHASES cycles after the accepting edge, counted in negative clock edges.
- R5: in_valid asserted while in_ready is 0 has no effect, either on the pending result or on the history used by later results.
- R6: A single sample of value 1 followed by zeros yields the coefficients c[0], c[1], …, c[TAPS−1] in order.
- R7: Samples are two's complement. The most significant bit carries weight −2^(IN_W−1), so the input −2^(IN_W−1) gives −2^(IN_W−1)·c[k] exactly.
- R8: Coefficient c[k] equals (((29k+11) mod 61) − 30)·(2^(COEF_W−1) − 1)/30, with the division truncated toward zero.
- R9: While reset is held and right after it, in_ready is 1, out_valid is 0 and out_data is 0.
- R10: out_data keeps its value in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed input sample |
| in_ready | output | 1 | Filter can take a sample this cycle |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | IN_W+COEF_W+ceil(log2 TAPS) | Signed full-precision result |

## Verification
The assertions assume three things about the inputs. First, reset is high at time zero for at least one edge. Second, a sample is transferred only on an edge where the host sees in_ready high. Third, in_valid seen while the filter is busy is not a transfer. The bench drives and samples on falling edges. It raises in_valid only after it has seen in_ready, except in the directed busy-window case. In that case it deliberately holds in_valid high with a junk value and drops it before in_ready returns, so that the ignore rule is exercised without forming a real transfer.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

   // Fixed tap value k for a COEF_W-bit signed coefficient set.
   function automatic int tap_coef(input int idx, input int cw);
      int raw;
      raw = ((idx * 29 + 11) % 61) - 30;
      return (raw * ((1 << (cw - 1)) - 1)) / 30;
   endfunction

   // Sum of the coefficients of group grp that are selected by the bits of addr.
   function automatic int group_sum(input int grp, input int gw, input int taps,
                                    input int cw, input int addr);
      int s;
      s = 0;
      for (int i = 0; i < gw; i++) begin
         if (((addr >> i) & 1) == 1 && (grp * gw + i) < taps)
            s += tap_coef(grp * gw + i, cw);
      end
      return s;
   endfunction

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/dafir_lut.sv
module dafir_lut import dafir_pkg::*; #(
   parameter int GRP    = 0,
   parameter int GW     = 2,
   parameter int TAPS   = 11,
   parameter int COEF_W = 14,
   parameter int OUT_W  = 19
) (
   input  logic [GW-1:0]           addr,
   output logic signed [OUT_W-1:0] val
);
   localparam int ENTRIES = 1 << GW;

   if (GW < 1 || GW > 6) begin : g_bad_gw
      $error("dafir_lut: GW must be 1..6");
   end

   logic signed [OUT_W-1:0] tbl [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam int SUMV = group_sum(GRP, GW, TAPS, COEF_W, e);
      assign tbl[e] = OUT_W'(SUMV);
   end

   assign val = tbl[addr];
endmodule

// File: rtl/dafir_bitsum.sv
module dafir_bitsum import dafir_pkg::*; #(
   parameter int TAPS   = 11,
   parameter int GW     = 2,
   parameter int COEF_W = 14,
   parameter int PW     = 19
) (
   input  logic [TAPS-1:0]       bits,
   output logic signed [PW-1:0]  psum
);
   localparam int NG   = ceil_div(TAPS, GW);
   localparam int PADW = NG * GW;

   logic [PADW-1:0]        padded;
   logic signed [PW-1:0]   part [NG];

   assign padded = PADW'(bits);

   for (genvar g = 0; g < NG; g++) begin : g_grp
      dafir_lut #(
         .GRP(g), .GW(GW), .TAPS(TAPS), .COEF_W(COEF_W), .OUT_W(PW)
      ) u_lut (
         .addr (padded[g*GW +: GW]),
         .val  (part[g])
      );
   end

   always_comb begin
      psum = '0;
      for (int g = 0; g < NG; g++) psum = psum + part[g];
   end
endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl #(
   parameter int PHASES = 4,
   localparam int PHW   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy,
   output logic last
);
   logic [PHW-1:0] cnt;
   logic [PHW-1:0] phase;

   assign phase = start ? '0 : cnt;
   assign last  = (start || busy) && (phase == PHW'(PHASES - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= (PHASES > 1);
         cnt  <= (PHASES > 1) ? PHW'(1) : '0;
      end else if (busy) begin
         if (cnt == PHW'(PHASES - 1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + PHW'(1);
         end
      end
   end
endmodule

// File: rtl/dafir_top.sv
module dafir_top import dafir_pkg::*; #(
   parameter int TAPS   = 11,
   parameter int IN_W   = 16,
   parameter int COEF_W = 14,
   parameter int BPC    = 4,
   parameter int GW     = 2,
   localparam int PHASES = IN_W / BPC,
   localparam int ACC_W  = IN_W + COEF_W + $clog2(TAPS),
   localparam int PW     = COEF_W + $clog2(TAPS) + 1,
   localparam int SW     = ACC_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [ACC_W-1:0] out_data
);
   if (BPC < 1 || BPC > IN_W || (IN_W % BPC) != 0) begin : g_bad_bpc
      $error("dafir_top: BPC must divide IN_W");
   end
   if (TAPS < 2) begin : g_bad_taps
      $error("dafir_top: TAPS must be at least 2");
   end
   if (COEF_W < 2 || COEF_W > 24) begin : g_bad_cw
      $error("dafir_top: COEF_W must be 2..24");
   end

   logic                  busy, last, accept;
   logic [IN_W-1:0]       hist    [TAPS-1];
   logic [IN_W-1:0]       work    [TAPS];
   logic [IN_W-1:0]       newtap  [TAPS];
   logic [IN_W-1:0]       src     [TAPS];
   logic [TAPS-1:0]       plane   [BPC];
   logic signed [PW-1:0]  psum    [BPC];
   logic signed [SW-1:0]  acc_hi, acc_base, q, sum, shifted;
   logic [IN_W-1:0]       low, low_next;
   logic [ACC_W-1:0]      result;

   assign in_ready = !busy;
   assign accept   = in_valid && !busy;

   dafir_ctrl #(.PHASES(PHASES)) u_ctrl (
      .clk(clk), .rst(rst), .start(accept), .busy(busy), .last(last)
   );

   // Tap view after the incoming sample has entered the delay line.
   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      if (k == 0) begin : g_head
         assign newtap[k] = in_data;
      end else begin : g_body
         assign newtap[k] = hist[k-1];
      end
      assign src[k] = accept ? newtap[k] : work[k];
   end

   always_comb begin
      for (int t = 0; t < BPC; t++)
         for (int k = 0; k < TAPS; k++)
            plane[t][k] = src[k][t];
   end

   for (genvar t = 0; t < BPC; t++) begin : g_plane
      dafir_bitsum #(
         .TAPS(TAPS), .GW(GW), .COEF_W(COEF_W), .PW(PW)
      ) u_bs (
         .bits (plane[t]),
         .psum (psum[t])
      );
   end

   // Combine the bit planes of this step; the sign plane is subtracted.
   always_comb begin
      logic signed [SW-1:0] term;
      q = '0;
      for (int t = 0; t < BPC; t++) begin
         term = {{(SW-PW){psum[t][PW-1]}}, psum[t]};
         term = term << t;
         if (last && t == BPC - 1) q = q - term;
         else                      q = q + term;
      end
   end

   assign acc_base = accept ? '0 : acc_hi;
   assign sum      = acc_base + q;
   assign shifted  = sum >>> BPC;

   if (BPC == IN_W) begin : g_full
      assign low_next = sum[IN_W-1:0];
   end else begin : g_part
      assign low_next = {sum[BPC-1:0], low[IN_W-1:BPC]};
   end

   assign result = {shifted[ACC_W-IN_W-1:0], low_next};

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
         for (int k = 0; k < TAPS; k++)     work[k] <= '0;
         acc_hi    <= '0;
         low       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= last;
         if (last) out_data <= result;
         if (accept) begin
            hist[0] <= in_data;
            for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
            for (int k = 0; k < TAPS; k++)     work[k] <= newtap[k] >> BPC;
         end else if (busy) begin
            for (int k = 0; k < TAPS; k++)     work[k] <= work[k] >> BPC;
         end
         if (accept || busy) begin
            acc_hi <= shifted;
            low    <= low_next;
         end
      end
   end
endmodule

// File: rtl/dafir_chk.sv
module dafir_chk #(
   parameter int PHASES = 4,
   parameter int ACC_W  = 34
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic [ACC_W-1:0] out_data
);
   logic started, armed, pend;
   int   age;

   always_ff @(posedge clk) begin
      started <= 1'b1;
      armed   <= !rst;
      if (rst) begin
         pend <= 1'b0;
         age  <= 0;
      end else if (in_valid && in_ready) begin
         pend <= 1'b1;
         age  <= 0;
      end else if (out_valid) begin
         pend <= 1'b0;
      end else if (pend) begin
         age <= age + 1;
      end
   end

   // R3: the filter is busy right after taking a sample
   p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && PHASES > 1) |=> !in_ready);

   // R3: ready again when the result appears
   p_done_ready_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_ready);

   // R4: result strobe lands PHASES-1 edges after the accepting edge
   p_out_timing_r4: assert property (@(posedge clk) disable iff (rst || !armed)
      out_valid |-> (pend && age == PHASES - 1));

   // R9: idle state right after reset
   p_reset_state_r9: assert property (@(posedge clk) disable iff (!started)
      $past(rst) |-> (in_ready && !out_valid && out_data == '0));

   // R10: result held between strobes
   p_hold_r10: assert property (@(posedge clk) disable iff (rst || !armed)
      !out_valid |-> $stable(out_data));
endmodule

bind dafir_top dafir_chk #(.PHASES(PHASES), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/dafir_top_tb_top.sv
module dafir_top_tb_top;
   localparam int TAPS   = 11;
   localparam int IN_W   = 16;
   localparam int COEF_W = 14;
   localparam int BPC    = 4;
   localparam int PHASES = IN_W / BPC;
   localparam int ACC_W  = IN_W + COEF_W + $clog2(TAPS);
   localparam int NVEC   = 20;
   localparam int VEC [NVEC] = '{1000, -1, 32767, -32768, 12345, -23456, 7, 0,
                                 -300, 255, 4096, -4097, 21845, -21846, 100,
                                 -100, 30000, -30000, 1, 2};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_data = '0;
   logic             in_ready, out_valid;
   logic [ACC_W-1:0] out_data;

   int     checks = 0;
   int     fails  = 0;
   longint hist [TAPS];

   always #2 clk = ~clk;

   dafir_top #(.TAPS(TAPS), .IN_W(IN_W), .COEF_W(COEF_W), .BPC(BPC)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
   );

   // R8 coefficient rule, written from the requirement
   function automatic longint coef(input int k);
      return longint'(((((k * 29 + 11) % 61) - 30) * ((1 << (COEF_W - 1)) - 1)) / 30);
   endfunction

   function automatic longint model_push(input int x);
      longint s;
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(x);
      s = 0;
      for (int k = 0; k < TAPS; k++) s += coef(k) * hist[k];
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Send one sample; optionally push junk during the busy window (R5).
   task automatic run_sample(input int x, input string req, input bit junk);
      longint expv, act, held;
      int     lat;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = IN_W'(x);
      @(posedge clk);
      lat = 0;
      expv = model_push(x);
      do begin
         @(negedge clk);
         lat++;
         in_valid = junk && (lat < PHASES);
         in_data  = junk ? 16'h5A5A : '0;
         if (junk && lat < PHASES) chk(in_ready == 1'b0, "R3 busy", longint'(in_ready), 0);
      end while (!out_valid && lat < 64);
      in_valid = 1'b0;
      act = longint'($signed(out_data));
      chk(act == expv, req, act, expv);
      chk(lat == PHASES, "R4 latency", longint'(lat), longint'(PHASES));
      chk(in_ready == 1'b1, "R3 ready at result", longint'(in_ready), 1);
      held = act;
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 single pulse", longint'(out_valid), 0);
      chk(longint'($signed(out_data)) == held, "R10 hold", longint'($signed(out_data)), held);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1 && out_valid == 1'b0 && out_data == '0, "R9 reset",
          longint'(out_data), 0);
      rst = 1'b0;

      // R1 R2: vector table after reset
      for (int i = 0; i < NVEC; i++) run_sample(VEC[i], "R1 vector", 1'b0);

      // R5: junk during busy window must not disturb this or later results
      run_sample(1234, "R5 busy ignore", 1'b1);
      run_sample(-777, "R5 later result", 1'b0);

      // R2 R9: reset in the middle of a computation
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = 16'h4000;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(in_ready == 1'b1 && out_valid == 1'b0 && out_data == '0, "R9 mid reset",
          longint'(out_data), 0);
      rst = 1'b0;
      for (int k = 0; k < TAPS; k++) hist[k] = 0;

      // R6/R8: unit impulse gives the coefficient list
      run_sample(1, "R6/R8 impulse", 1'b0);
      for (int k = 1; k < TAPS; k++) run_sample(0, "R6/R8 impulse tail", 1'b0);

      // R7: most negative sample, then flush
      run_sample(-32768, "R7 min sample", 1'b0);
      for (int k = 1; k < TAPS; k++) run_sample(0, "R7 min tail", 1'b0);
      run_sample(32767, "R7 max sample", 1'b0);
      run_sample(-32768, "R7 swing", 1'b0);

      repeat (4) @(negedge clk);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule